// File: doc/BRIEF.md
# GPIO Output Blink Controller

This block holds the output configuration of a bank of general-purpose pins and produces the value each pin drives. Each pin has an output-enable bit and a stored drive-level bit. A third register selects pins that blink instead of driving their level: a blinking output pin drives a shared square wave with a period of about one second, high for half of it and low for the other half. The usual use is a status LED that software starts and stops with one register write.

A single free-running prescaler divides the system clock by `CLK_HZ/2` to produce the shared blink phase, so all blinking pins switch on the same edge. Blinking does not touch the stored level bit. When blinking stops, the pin goes straight back to its stored level.

The blink-enable register has only three writable bits, split across two reset groups. Bit 25 is in the standby-powered group. It is cleared by the standby reset, by a software reset request, or by the platform reset. Bits 19 and 18 are in the main-powered group and only the platform reset returns them to their reset value. Every other bit of that register reads as zero and ignores writes.

Top module: `gpio_blink_ctrl`

## Requirements
- R1: After the platform reset is released, the blink phase is high for `CLK_HZ/2` clock edges, then low for `CLK_HZ/2` edges, and repeats. An output pin whose blink bit is set drives this phase on `pin_out`.
- R2: A pin whose output-enable bit (address 0) is 0 has `pin_oe` low and `pin_out` low, whatever its blink bit holds.
- R3: An output pin whose blink bit is 0 drives its stored level bit (address 1) on `pin_out`.
- R4: The level register changes only on a write to address 1 or on the platform reset. Setting, clearing or running blink never alters it, and it reads back unchanged.
- R5: In the blink-enable register (address 2), only bits 25, 19 and 18 are writable. All other bits read 0 after any write.
- R6: While `plat_rst` is high, the blink register returns to 0x00040000, the output-enable and level registers return to 0, and the blink phase restarts high.
- R7: A cycle with `stby_rst` or `sw_rst` high clears blink bit 25. It leaves bits 19 and 18 and the output-enable and level registers unchanged.
- R8: When a reset and a register write fall in the same cycle, the reset wins for the bits it covers. Write data still lands in bits the reset does not cover.
- R9: `reg_rdata` shows the addressed register's current contents with no clock delay. Address 3 reads 0, and a write takes effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| plat_rst | input | 1 | Platform reset, synchronous, active high; clears all registers and the prescaler |
| stby_rst | input | 1 | Standby-group reset, synchronous, active high |
| sw_rst | input | 1 | Software reset request, synchronous, active high; affects the standby group only |
| reg_addr | input | 2 | Register select: 0 output enable, 1 level, 2 blink enable, 3 unused |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| pin_oe | output | 32 | Per-pin output enable |
| pin_out | output | 32 | Per-pin driven value |

## Verification
The main same-cycle collision is a reset of one group arriving in the same cycle as a write to the blink register. The bench asserts the standby reset together with a write that sets bits 25 and 19, and expects bit 25 to be clear and bit 19 to be set afterwards. It then repeats this with the platform reset, which must win over every bit. The second collision is a register write landing on the same edge as a phase flip. The bench enables blink pins mid-period while it tracks the expected phase from its own count of edges since reset. Every cycle it compares `pin_out` with a mask formed arithmetically from the output-enable, blink and level patterns.

// File: rtl/gpio_blink_pkg.sv
package gpio_blink_pkg;

   typedef enum logic [1:0] {
      REG_OE    = 2'd0,
      REG_LVL   = 2'd1,
      REG_BLINK = 2'd2,
      REG_NONE  = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/blink_prescaler.sv
module blink_prescaler #(
   parameter int CLK_HZ = 100_000_000
) (
   input  logic clk,
   input  logic plat_rst,
   output logic phase
);
   localparam int HALF_CYC = CLK_HZ / 2;
   localparam int CNT_W    = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

   if (CLK_HZ < 4) begin : g_bad_clk
      $error("blink_prescaler: CLK_HZ must be at least 4");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (plat_rst) begin
         cnt_q <= '0;
         phase <= 1'b1;
      end else if (cnt_q == CNT_W'(HALF_CYC - 1)) begin
         cnt_q <= '0;
         phase <= ~phase;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/cfg_word_reg.sv
module cfg_word_reg #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              plat_rst,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (plat_rst)  q <= '0;
      else if (we)   q <= wdata;
   end
endmodule

// File: rtl/blink_enable_reg.sv
module blink_enable_reg #(
   parameter int              DATA_W    = 32,
   parameter logic [DATA_W-1:0] WR_MASK   = 32'h020C_0000,
   parameter logic [DATA_W-1:0] STBY_MASK = 32'h0200_0000,
   parameter logic [DATA_W-1:0] RST_VAL   = 32'h0004_0000
) (
   input  logic              clk,
   input  logic              plat_rst,
   input  logic              stby_clr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   if ((STBY_MASK & ~WR_MASK) != '0) begin : g_bad_stby
      $error("blink_enable_reg: standby bits must be writable bits");
   end
   if ((RST_VAL & ~WR_MASK) != '0) begin : g_bad_rst
      $error("blink_enable_reg: reset value sets a reserved bit");
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (STBY_MASK[i]) begin : g_stby
         always_ff @(posedge clk) begin
            if (plat_rst || stby_clr) q[i] <= RST_VAL[i];
            else if (we)              q[i] <= wdata[i];
         end
      end else if (WR_MASK[i]) begin : g_main
         always_ff @(posedge clk) begin
            if (plat_rst)  q[i] <= RST_VAL[i];
            else if (we)   q[i] <= wdata[i];
         end
      end else begin : g_rsvd
         assign q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/pin_drive_mux.sv
module pin_drive_mux #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] oe,
   input  logic [DATA_W-1:0] lvl,
   input  logic [DATA_W-1:0] blink,
   input  logic              phase,
   output logic [DATA_W-1:0] pin_out
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_pin
      assign pin_out[i] = oe[i] & (blink[i] ? phase : lvl[i]);
   end
endmodule

// File: rtl/gpio_blink_ctrl.sv
module gpio_blink_ctrl
   import gpio_blink_pkg::*;
#(
   parameter int              CLK_HZ    = 100_000_000,
   parameter int              DATA_W    = 32,
   parameter logic [DATA_W-1:0] WR_MASK   = 32'h020C_0000,
   parameter logic [DATA_W-1:0] STBY_MASK = 32'h0200_0000,
   parameter logic [DATA_W-1:0] RST_VAL   = 32'h0004_0000
) (
   input  logic              clk,
   input  logic              plat_rst,
   input  logic              stby_rst,
   input  logic              sw_rst,
   input  logic [1:0]        reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [DATA_W-1:0] pin_oe,
   output logic [DATA_W-1:0] pin_out
);
   localparam int HALF_CYC = CLK_HZ / 2;

   reg_sel_e          sel;
   logic [DATA_W-1:0] oe_q, lvl_q, blink_q;
   logic              phase;

   assign sel = reg_sel_e'(reg_addr);

   cfg_word_reg #(.DATA_W(DATA_W)) i_oe_reg (
      .clk(clk), .plat_rst(plat_rst),
      .we(reg_we && sel == REG_OE), .wdata(reg_wdata), .q(oe_q));

   cfg_word_reg #(.DATA_W(DATA_W)) i_lvl_reg (
      .clk(clk), .plat_rst(plat_rst),
      .we(reg_we && sel == REG_LVL), .wdata(reg_wdata), .q(lvl_q));

   blink_enable_reg #(
      .DATA_W(DATA_W), .WR_MASK(WR_MASK),
      .STBY_MASK(STBY_MASK), .RST_VAL(RST_VAL)
   ) i_blink_reg (
      .clk(clk), .plat_rst(plat_rst), .stby_clr(stby_rst || sw_rst),
      .we(reg_we && sel == REG_BLINK), .wdata(reg_wdata), .q(blink_q));

   blink_prescaler #(.CLK_HZ(CLK_HZ)) i_presc (
      .clk(clk), .plat_rst(plat_rst), .phase(phase));

   pin_drive_mux #(.DATA_W(DATA_W)) i_mux (
      .oe(oe_q), .lvl(lvl_q), .blink(blink_q), .phase(phase),
      .pin_out(pin_out));

   assign pin_oe = oe_q;

   always_comb begin
      case (sel)
         REG_OE:    reg_rdata = oe_q;
         REG_LVL:   reg_rdata = lvl_q;
         REG_BLINK: reg_rdata = blink_q;
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_blink_chk.sv
module gpio_blink_chk #(
   parameter int              DATA_W    = 32,
   parameter int              HALF_CYC  = 4,
   parameter logic [DATA_W-1:0] WR_MASK   = 32'h020C_0000,
   parameter logic [DATA_W-1:0] STBY_MASK = 32'h0200_0000,
   parameter logic [DATA_W-1:0] RST_VAL   = 32'h0004_0000
) (
   input logic              clk,
   input logic              plat_rst,
   input logic              stby_rst,
   input logic              sw_rst,
   input logic [1:0]        reg_addr,
   input logic              reg_we,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [DATA_W-1:0] pin_oe,
   input logic [DATA_W-1:0] pin_out,
   input logic [DATA_W-1:0] blink_q,
   input logic [DATA_W-1:0] lvl_q,
   input logic              phase
);
   localparam int RW = $clog2(HALF_CYC) + 1;
   logic [RW-1:0] run_cnt;

   always_ff @(posedge clk) begin
      if (plat_rst)                               run_cnt <= '0;
      else if (run_cnt == RW'(HALF_CYC - 1))      run_cnt <= '0;
      else                                        run_cnt <= run_cnt + 1'b1;
   end

   // R1: phase holds between wrap points
   p_phase_hold_r1: assert property (@(posedge clk) disable iff (plat_rst)
      (run_cnt != RW'(HALF_CYC - 1)) |=> $stable(phase));

   // R1: phase flips at each wrap
   p_phase_flip_r1: assert property (@(posedge clk) disable iff (plat_rst)
      (run_cnt == RW'(HALF_CYC - 1)) |=> (phase != $past(phase)));

   // R2: disabled pins never drive high
   p_input_quiet_r2: assert property (@(posedge clk) disable iff (plat_rst)
      ((pin_out & ~pin_oe) == '0));

   // R4: level register moves only on its own write
   p_level_hold_r4: assert property (@(posedge clk) disable iff (plat_rst)
      !(reg_we && reg_addr == 2'd1) |=> $stable(lvl_q));

   // R5: reserved blink bits read zero
   p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (plat_rst)
      (reg_addr == 2'd2) |-> ((reg_rdata & ~WR_MASK) == '0));

   // R6: blink register holds its reset value right after reset
   p_reset_val_r6: assert property (@(posedge clk) disable iff (plat_rst)
      $fell(plat_rst) |-> (blink_q == RST_VAL));

   // R7: standby clear touches only the standby group
   p_stby_clear_r7: assert property (@(posedge clk) disable iff (plat_rst)
      ((stby_rst || sw_rst) && !(reg_we && reg_addr == 2'd2))
      |=> (blink_q == ($past(blink_q) & ~STBY_MASK)));
endmodule

bind gpio_blink_ctrl gpio_blink_chk #(
   .DATA_W(DATA_W), .HALF_CYC(HALF_CYC), .WR_MASK(WR_MASK),
   .STBY_MASK(STBY_MASK), .RST_VAL(RST_VAL)
) i_chk (
   .clk(clk), .plat_rst(plat_rst), .stby_rst(stby_rst), .sw_rst(sw_rst),
   .reg_addr(reg_addr), .reg_we(reg_we), .reg_rdata(reg_rdata),
   .pin_oe(pin_oe), .pin_out(pin_out), .blink_q(blink_q),
   .lvl_q(lvl_q), .phase(phase)
);

// File: tb/test_gpio_blink_ctrl.sv
module test_gpio_blink_ctrl;
   localparam int CLK_HZ = 8;
   localparam int HALF   = CLK_HZ / 2;
   localparam logic [31:0] MASK = 32'h020C_0000;
   localparam logic [31:0] RSTV = 32'h0004_0000;

   logic        clk = 1'b0;
   logic        plat_rst = 1'b1, stby_rst = 1'b0, sw_rst = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata, pin_oe, pin_out;

   int vectors = 0, miscompares = 0, cyc = 0;
   bit done = 0;

   gpio_blink_ctrl #(.CLK_HZ(CLK_HZ)) i_gpio_blink_ctrl (
      .clk(clk), .plat_rst(plat_rst), .stby_rst(stby_rst), .sw_rst(sw_rst),
      .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .pin_oe(pin_oe), .pin_out(pin_out));

   always #4 clk = ~clk;

   always @(posedge clk) begin
      if (plat_rst) cyc <= 0;
      else          cyc <= cyc + 1;
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
      reg_addr = a;
      #1;
      chk(reg_rdata, exp, tag);
   endtask

   function automatic logic [31:0] expect_pins(input logic [31:0] oe, input logic [31:0] lv,
                                              input logic [31:0] bl, input int c);
      logic ph = ((c / HALF) % 2) == 0;
      return oe & ((bl & {32{ph}}) | (~bl & lv));
   endfunction

   task automatic run_blink(input logic [31:0] oe, input logic [31:0] lv,
                            input logic [31:0] bl, input int n, input string tag);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         #1;
         chk(pin_out, expect_pins(oe, lv, bl, cyc), tag);
         chk(pin_oe, oe, "R2 oe");
         rd(2'd1, lv, "R4 level kept");
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      plat_rst = 1'b0;
      // R6 reset state
      rd(2'd2, RSTV, "R6 blink reset");
      rd(2'd0, 32'h0, "R6 oe reset");
      rd(2'd1, 32'h0, "R6 level reset");
      chk(pin_out, 32'h0, "R6 pins reset");
      rd(2'd3, 32'h0, "R9 unused addr");

      // R5 writable-bit sweep
      wr(2'd2, 32'hFFFF_FFFF);
      rd(2'd2, MASK, "R5 all ones");
      for (int i = 0; i < 32; i++) begin
         wr(2'd2, 32'h1 << i);
         rd(2'd2, (32'h1 << i) & MASK, "R5 single bit");
      end
      wr(2'd2, 32'h0);

      // R9 write timing: visible right after the edge
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h1234_5678;
      #1 chk(reg_rdata, 32'h0, "R9 before edge");
      @(negedge clk);
      reg_we = 1'b0;
      #1 chk(reg_rdata, 32'h1234_5678, "R9 after edge");

      // R3 plain level drive
      wr(2'd0, 32'hFFFF_FFFF);
      wr(2'd1, 32'hA5A5_0F0F);
      @(negedge clk); #1;
      chk(pin_out, 32'hA5A5_0F0F, "R3 level drive");
      wr(2'd1, 32'h5A5A_F0F0);
      @(negedge clk); #1;
      chk(pin_out, 32'h5A5A_F0F0, "R3 level drive 2");

      // R1 blink on all writable bits, enabled mid-period
      wr(2'd2, MASK);
      run_blink(32'hFFFF_FFFF, 32'h5A5A_F0F0, MASK, 6 * HALF, "R1 blink");

      // R2 blink bits on input pins
      wr(2'd0, ~32'h0204_0000);
      run_blink(~32'h0204_0000, 32'h5A5A_F0F0, MASK, 4 * HALF, "R2 input pin");
      wr(2'd0, 32'hFFFF_FFFF);

      // R3 blink cleared returns to level
      wr(2'd2, 32'h0);
      run_blink(32'hFFFF_FFFF, 32'h5A5A_F0F0, 32'h0, 2 * HALF, "R3 blink off");

      // R7 software reset and standby reset
      wr(2'd2, MASK);
      @(negedge clk); sw_rst = 1'b1; @(negedge clk); sw_rst = 1'b0;
      rd(2'd2, 32'h000C_0000, "R7 sw clear");
      rd(2'd0, 32'hFFFF_FFFF, "R7 oe kept");
      rd(2'd1, 32'h5A5A_F0F0, "R7 level kept");
      wr(2'd2, MASK);
      @(negedge clk); stby_rst = 1'b1; @(negedge clk); stby_rst = 1'b0;
      rd(2'd2, 32'h000C_0000, "R7 stby clear");

      // R8 standby reset colliding with a write
      wr(2'd2, 32'h0204_0000);
      @(negedge clk);
      stby_rst = 1'b1; reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h0208_0000;
      @(negedge clk);
      stby_rst = 1'b0; reg_we = 1'b0;
      rd(2'd2, 32'h0008_0000, "R8 stby vs write");

      // R8 platform reset colliding with a write
      @(negedge clk);
      plat_rst = 1'b1; reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = MASK;
      @(negedge clk);
      plat_rst = 1'b0; reg_we = 1'b0;
      rd(2'd2, RSTV, "R8 plat vs write");
      rd(2'd0, 32'h0, "R6 oe after plat");
      rd(2'd1, 32'h0, "R6 level after plat");

      // R1 phase restarts high after platform reset
      wr(2'd0, 32'h0004_0000);
      run_blink(32'h0004_0000, 32'h0, RSTV, 4 * HALF, "R1 after reset");

      done = 1;
      summary();
   end
endmodule